// File: doc/BRIEF.md
# Self-Triggered Event Capture Controller

This block runs the acquisition phase of a 36-channel front-end that triggers on its own. Each channel delivers a discriminator bit. The block ORs these bits into a single chip trigger. An external force input can also start a capture when no discriminator has fired. A 12-bit coarse timestamp counts bunch-crossing ticks from the start-of-acquisition strobe. When a trigger is accepted, the block writes the current timestamp and the 36-bit hit pattern into the next free slot of a 16-entry event store. It then advances the write pointer and pulses a hold strobe for the analog sample cells. A per-slot valid map tells those cells which samples they hold.

After a capture the trigger stays disarmed until the next bunch-crossing tick. This gives at most one event per crossing. Once all slots are filled, the block drives a full flag in open-collector style: a 1 means it pulls the shared line low. It then accepts no more events. The shared line is also read back, so that any chip on the bus that reports full halts this one as well. A combinational read port gives access to the stored slots for the conversion stage that follows.

Top module: `acq_ctrl`

## Requirements
- R1: After reset the block is idle. The pointer is 0, full is 0, armed is 0, the valid map is 0, the timestamp is 0 and hold is 0. Triggers are ignored until the first start strobe.
- R2: A start strobe clears the pointer, the valid map, the full flag and the timestamp, and arms the trigger. All of these take effect on the next cycle.
- R3: Each bunch-crossing tick increments the 12-bit timestamp by one, wrapping from 4095 to 0. A start strobe in the same cycle wins and clears the timestamp to 0.
- R4: An accepted trigger writes the hit pattern and the pre-edge timestamp into the slot at the write pointer. The pointer then advances by one. Slot k is read back on the read port when rd_slot = k.
- R5: Several discriminator bits that are high in the same cycle produce a single slot, and its hit pattern holds every bit that was high. Bit i of the hit pattern is channel i.
- R6: force_trig with all discriminators low captures an event whose hit pattern is all zeros.
- R7: After a capture the trigger is disarmed. Trigger inputs are ignored until a tick re-arms it. The tick re-arms in the cycle it is seen, so a trigger in the cycle after the tick is captured. A capture in the same cycle as a tick leaves the trigger disarmed.
- R8: hold_o is high for exactly the one cycle after each capture edge. At the same edge, bit k of slot_valid_o is set for the slot k just written.
- R9: The 16th capture sets full_pull_o (1 = line pulled low). While full, triggers change neither the pointer nor the valid map. Only a start strobe clears full.
- R10: While the shared line full_bus_n is low, no trigger is accepted and the pointer does not move.
- R11: A start strobe in the same cycle as a trigger takes priority, and no capture happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_start | input | 1 | Start-of-acquisition strobe |
| bx_tick | input | 1 | Bunch-crossing clock enable |
| disc_in | input | 36 | Per-channel discriminator bits |
| force_trig | input | 1 | External trigger without a discriminator |
| full_bus_n | input | 1 | Shared full line as sensed (0 = some chip is full) |
| rd_slot | input | 4 | Slot index for the read port |
| full_pull_o | output | 1 | Drive for the shared full line (1 = pull low) |
| hold_o | output | 1 | One-cycle hold strobe after a capture |
| slot_valid_o | output | 16 | Map of filled slots |
| wr_ptr_o | output | 4 | Next slot to write |
| armed_o | output | 1 | Trigger is armed |
| bcid_o | output | 12 | Current coarse timestamp |
| rd_hits_o | output | 36 | Hit pattern of the slot at rd_slot |
| rd_bcid_o | output | 12 | Timestamp of the slot at rd_slot |

## Verification
The assertions assume that bx_tick is a single-cycle enable, that acq_start is a strobe, and that full_bus_n reflects a level the other chips hold for whole cycles. The bench drives all of these on the falling edge as clean one-cycle levels. It applies the start strobe only between events or together with a trigger (for R11), and it holds full_bus_n low for one block of cycles at a time. The same applies to the discriminator pattern: the bench always keeps it stable across the rising edge.

// File: rtl/acq_pkg.sv
package acq_pkg;
  // increment modulo m
  function automatic int wrap_inc(int v, int m);
    return (v + 1 >= m) ? 0 : v + 1;
  endfunction

  // true when index p is the last of a store of depth d
  function automatic logic is_last(int p, int d);
    return p == d - 1;
  endfunction

  // any bit set or forced
  function automatic logic any_fire(logic [63:0] bits, logic frc);
    return (|bits) | frc;
  endfunction
endpackage

// File: rtl/acq_bcid_ctr.sv
module acq_bcid_ctr #(
  parameter int TS_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick,
  output logic [TS_W-1:0] bcid
);
  localparam int TS_MOD = 1 << TS_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcid <= '0;
    else if (clr)  bcid <= '0;
    else if (tick) bcid <= TS_W'(acq_pkg::wrap_inc(int'(bcid), TS_MOD));
  end
endmodule

// File: rtl/acq_trig_gate.sv
module acq_trig_gate #(
  parameter int NCH = 36
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           tick,
  input  logic [NCH-1:0] disc,
  input  logic           force_in,
  input  logic           halt,
  output logic           cap,
  output logic           armed
);
  logic running;
  logic fire;

  assign fire = acq_pkg::any_fire(64'(disc), force_in);
  assign cap  = armed & ~start & ~halt & fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      armed   <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      armed   <= 1'b1;
    end else if (cap) begin
      armed   <= 1'b0;
    end else if (tick && running) begin
      armed   <= 1'b1;
    end
  end
endmodule

// File: rtl/acq_evt_store.sv
module acq_evt_store #(
  parameter int NCH   = 36,
  parameter int DEPTH = 16,
  parameter int TS_W  = 12,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [TS_W-1:0]  ts_in,
  input  logic [NCH-1:0]   hits_in,
  input  logic [PTR_W-1:0] rd_slot,
  output logic [PTR_W-1:0] ptr,
  output logic             full,
  output logic [DEPTH-1:0] valid,
  output logic [NCH-1:0]   rd_hits,
  output logic [TS_W-1:0]  rd_ts
);
  logic [NCH-1:0]  hit_q [DEPTH];
  logic [TS_W-1:0] ts_q  [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      full <= 1'b0;
    end else if (clr) begin
      ptr  <= '0;
      full <= 1'b0;
    end else if (we) begin
      ptr <= PTR_W'(acq_pkg::wrap_inc(int'(ptr), DEPTH));
      if (acq_pkg::is_last(int'(ptr), DEPTH)) full <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel;
    assign sel = we && (ptr == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid[g] <= 1'b0;
        hit_q[g] <= '0;
        ts_q[g]  <= '0;
      end else if (clr) begin
        valid[g] <= 1'b0;
      end else if (sel) begin
        valid[g] <= 1'b1;
        hit_q[g] <= hits_in;
        ts_q[g]  <= ts_in;
      end
    end
  end

  assign rd_hits = hit_q[rd_slot];
  assign rd_ts   = ts_q[rd_slot];
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl #(
  parameter int NCH   = 36,
  parameter int DEPTH = 16,
  parameter int TS_W  = 12,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_start,
  input  logic             bx_tick,
  input  logic [NCH-1:0]   disc_in,
  input  logic             force_trig,
  input  logic             full_bus_n,
  input  logic [PTR_W-1:0] rd_slot,
  output logic             full_pull_o,
  output logic             hold_o,
  output logic [DEPTH-1:0] slot_valid_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic             armed_o,
  output logic [TS_W-1:0]  bcid_o,
  output logic [NCH-1:0]   rd_hits_o,
  output logic [TS_W-1:0]  rd_bcid_o
);
  // named internal events for the checker
  logic cap_w;
  logic halt_w;
  logic full_w;

  assign halt_w = full_w | ~full_bus_n;

  acq_bcid_ctr #(.TS_W(TS_W)) u_bcid (
    .clk(clk), .rst_n(rst_n), .clr(acq_start), .tick(bx_tick), .bcid(bcid_o)
  );

  acq_trig_gate #(.NCH(NCH)) u_gate (
    .clk(clk), .rst_n(rst_n), .start(acq_start), .tick(bx_tick),
    .disc(disc_in), .force_in(force_trig), .halt(halt_w),
    .cap(cap_w), .armed(armed_o)
  );

  acq_evt_store #(.NCH(NCH), .DEPTH(DEPTH), .TS_W(TS_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(acq_start), .we(cap_w),
    .ts_in(bcid_o), .hits_in(disc_in), .rd_slot(rd_slot),
    .ptr(wr_ptr_o), .full(full_w), .valid(slot_valid_o),
    .rd_hits(rd_hits_o), .rd_ts(rd_bcid_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_o <= 1'b0;
    else        hold_o <= cap_w;
  end

  assign full_pull_o = full_w;
endmodule

// File: rtl/acq_ctrl_chk.sv
module acq_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int TS_W  = 12,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acq_start,
  input logic             bx_tick,
  input logic             full_bus_n,
  input logic             cap,
  input logic             armed_o,
  input logic             hold_o,
  input logic             full_pull_o,
  input logic [PTR_W-1:0] wr_ptr_o,
  input logic [DEPTH-1:0] slot_valid_o,
  input logic [TS_W-1:0]  bcid_o
);
  p_hold_after_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> hold_o);

  p_hold_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> $past(cap));

  p_valid_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> $countones(slot_valid_o) == $past($countones(slot_valid_o)) + 1);

  p_disarm_after_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> !armed_o);

  p_frozen_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full_pull_o && !acq_start |=> $stable(wr_ptr_o) && full_pull_o);

  p_full_means_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full_pull_o |-> &slot_valid_o);

  p_bus_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !full_bus_n |-> !cap);

  p_bcid_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bx_tick && !acq_start |=> bcid_o == TS_W'($past(bcid_o) + 1'b1));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |=> wr_ptr_o == '0 && !full_pull_o && armed_o && bcid_o == '0);
endmodule

bind acq_ctrl acq_ctrl_chk #(.DEPTH(DEPTH), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .bx_tick(bx_tick),
  .full_bus_n(full_bus_n), .cap(cap_w), .armed_o(armed_o), .hold_o(hold_o),
  .full_pull_o(full_pull_o), .wr_ptr_o(wr_ptr_o), .slot_valid_o(slot_valid_o),
  .bcid_o(bcid_o)
);

// File: tb/acq_ctrl_tb.sv
module acq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acq_start = 1'b0, bx_tick = 1'b0, force_trig = 1'b0;
  logic        full_bus_n = 1'b1;
  logic [35:0] disc_in = '0;
  logic [3:0]  rd_slot = '0;
  logic        full_pull_o, hold_o, armed_o;
  logic [15:0] slot_valid_o;
  logic [3:0]  wr_ptr_o;
  logic [11:0] bcid_o, rd_bcid_o;
  logic [35:0] rd_hits_o;

  acq_ctrl u_dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  int          m_bcid, m_ptr;
  bit          m_full, m_armed, m_run, m_hold;
  logic [15:0] m_valid;
  logic [35:0] m_hits [16];
  int          m_ts   [16];

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_bcid = 0; m_ptr = 0; m_full = 0; m_armed = 0; m_run = 0; m_hold = 0;
    m_valid = '0;
  endtask

  // one clock: drive at negedge, update model, sample at next negedge
  task automatic cyc(logic [35:0] d, bit frc, bit tk, bit st, bit busn);
    bit cap;
    disc_in = d; force_trig = frc; bx_tick = tk; acq_start = st; full_bus_n = busn;
    @(negedge clk);
    if (st) begin
      m_bcid = 0; m_ptr = 0; m_full = 0; m_valid = '0;
      m_armed = 1; m_run = 1; m_hold = 0;
    end else begin
      cap = m_armed && !m_full && busn && ((d != 0) || frc);
      m_hold = cap;
      if (cap) begin
        m_hits[m_ptr] = d; m_ts[m_ptr] = m_bcid; m_valid[m_ptr] = 1'b1;
        if (m_ptr == 15) m_full = 1;
        m_ptr = (m_ptr + 1) % 16;
        m_armed = 0;
      end else if (tk && m_run) m_armed = 1;
      if (tk) m_bcid = (m_bcid + 1) % 4096;
    end
    chk("R4", "wr_ptr", wr_ptr_o, m_ptr);
    chk("R8", "slot_valid", slot_valid_o, m_valid);
    chk("R8", "hold", hold_o, m_hold);
    chk("R7", "armed", armed_o, m_armed);
    chk("R9", "full_pull", full_pull_o, m_full);
    chk("R3", "bcid", bcid_o, m_bcid);
    disc_in = '0; force_trig = 0; bx_tick = 0; acq_start = 0; full_bus_n = 1;
  endtask

  task automatic readback(string req, int k);
    rd_slot = 4'(k);
    #1;
    chk(req, "rd_hits", rd_hits_o, m_hits[k]);
    chk(req, "rd_bcid", rd_bcid_o, m_ts[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "ptr", wr_ptr_o, 0);
    chk("R1", "full", full_pull_o, 0);
    chk("R1", "armed", armed_o, 0);
    chk("R1", "valid", slot_valid_o, 0);
    chk("R1", "bcid", bcid_o, 0);
    chk("R1", "hold", hold_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: triggers ignored before start, even across ticks
    cyc(36'hF, 1, 1, 0, 1);
    cyc(36'h1, 0, 0, 0, 1);
    chk("R1", "no capture before start", slot_valid_o, 0);

    // R2: start arms and clears
    cyc('0, 0, 1, 1, 1);
    chk("R2", "armed after start", armed_o, 1);
    chk("R2", "bcid after start", bcid_o, 0);

    // R4 R7 R8 R9: sweep single channels, fill store, overflow attempts
    for (int round = 0; round < 3; round++) begin
      cyc('0, 0, 0, 1, 1);
      for (int s = 0; s < 16; s++) begin
        int ch = (s * 7 + round * 13) % 36;
        cyc(36'(1) << ch, 0, 0, 0, 1);
        // R7: a second trigger before the tick is ignored
        cyc(36'(1) << ((ch + 1) % 36), 0, 0, 0, 1);
        for (int t = 0; t < round + 1; t++) cyc('0, 0, 1, 0, 1);
      end
      chk("R9", "full after 16", full_pull_o, 1);
      for (int s = 0; s < 16; s++) readback("R4", s);
      // R9: triggers while full leave pointer alone
      for (int t = 0; t < 4; t++) cyc('1, 1, 1, 0, 1);
      chk("R9", "ptr held while full", wr_ptr_o, 0);
    end

    // R5: merged hits; R6: forced event; R7 capture on tick stays disarmed
    cyc('0, 0, 0, 1, 1);
    cyc(36'h8_0000_0F01, 0, 0, 0, 1);
    readback("R5", 0);
    cyc('0, 0, 1, 0, 1);
    cyc('0, 1, 0, 0, 1);
    readback("R6", 1);
    chk("R6", "forced map empty", rd_hits_o, 0);
    cyc('0, 0, 1, 0, 1);
    cyc(36'hF_FFFF_FFFF, 0, 1, 0, 1);
    chk("R7", "disarmed after capture on tick", armed_o, 0);
    readback("R5", 2);

    // R10: shared line low blocks capture
    cyc('0, 0, 1, 0, 1);
    for (int t = 0; t < 5; t++) cyc(36'h3, 1, t[0], 0, 0);
    chk("R10", "ptr unchanged while bus low", wr_ptr_o, 3);
    cyc(36'h3, 0, 0, 0, 1);
    chk("R10", "capture resumes", wr_ptr_o, 4);

    // R11: start wins over trigger
    cyc('0, 0, 1, 0, 1);
    cyc(36'h5, 1, 0, 1, 1);
    chk("R11", "no capture with start", slot_valid_o, 0);
    chk("R11", "hold", hold_o, 0);

    // R3: timestamp wrap, then capture with wrapped stamp
    for (int t = 0; t < 4100; t++) cyc('0, 0, 1, 0, 1);
    chk("R3", "bcid wrapped", bcid_o, 4);
    cyc(36'h10, 0, 0, 0, 1);
    readback("R4", 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule